// File: doc/BRIEF.md
# Bus-Mapped I/O Pin Bank with Atomic Bit Operations

This block is a general purpose pin bank on a simple word-addressed register bus with Wishbone classic cycles. It keeps two registers: a drive-enable register and an output-level register. Each register has four addresses. The first replaces the register. The second sets the masked bits, the third clears them and the fourth inverts them. Software can therefore change a few pins in one bus write, with no read-modify-write sequence. Concurrent software threads that own different pins do not interfere with each other.

A fifth, read-only address returns the pin inputs after a two-flop synchronizer. The pin outputs are the output-level register gated bit by bit with the drive enable. Both registers clear on reset, so every pin starts as a non-driving input. The bus completes every access with a single-cycle acknowledge. Addresses that are not mapped read as zero, and writes to them are dropped.

Top module: `gpio_alias_port`

## Requirements
- R1: While and after reset, the drive-enable and output-level registers are zero, `pin_oe_o` and `pin_out_o` are zero and `bus_ack_o` is low.
- R2: A request (`bus_cyc_i` and `bus_stb_i` high while `bus_ack_o` is low) gets `bus_ack_o` high for exactly one cycle on the next clock. There is never an acknowledge without a request.
- R3: The word index is `bus_adr_i[ADDR_W-1:2]`, and `bus_adr_i[1:0]` is ignored. The drive-enable register uses byte offsets 0x00 (replace), 0x04 (set), 0x08 (clear) and 0x0C (invert). The output-level register uses 0x10, 0x14, 0x18 and 0x1C in the same order. The synchronized inputs are at 0x20, which is read-only.
- R4: A replace write loads the enabled byte lanes of `bus_dat_i` into the register. Bits above `NUM_PINS` are discarded.
- R5: A set write ORs the lane-masked write data into the register. No bit goes from 1 to 0.
- R6: A clear write forces the lane-masked data bits to 0. No bit goes from 0 to 1.
- R7: An invert write flips exactly the lane-masked data bits.
- R8: A read of any of the four addresses of a register returns its current value, zero-extended to `DATA_W`.
- R9: `pin_oe_o` equals the drive-enable register. `pin_out_o` equals the output level ANDed with the drive enable.
- R10: A read at 0x20 returns `pin_in_i` through two flops. A change made half a cycle before a read request is not yet seen by that read; it is seen by a later read.
- R11: Reads of unmapped offsets return zero. Writes to unmapped offsets, and writes to 0x20, change no register.
- R12: Bit 8k+j of the write data takes part only when `bus_sel_i[k]` is 1. A write with `bus_sel_i` all zero leaves both registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| bus_cyc_i | input | 1 | Bus cycle valid |
| bus_stb_i | input | 1 | Bus strobe |
| bus_we_i | input | 1 | 1 for write, 0 for read |
| bus_adr_i | input | ADDR_W | Byte address |
| bus_dat_i | input | DATA_W | Write data |
| bus_sel_i | input | DATA_W/8 | Byte lane enables |
| bus_dat_o | output | DATA_W | Read data, valid with acknowledge |
| bus_ack_o | output | 1 | Single-cycle acknowledge |
| pin_in_i | input | NUM_PINS | Asynchronous pin inputs |
| pin_out_o | output | NUM_PINS | Pin output levels, gated by drive enable |
| pin_oe_o | output | NUM_PINS | Per-pin drive enable, 1 drives |

## Verification
The bench applies set, clear and invert masks that overlap partly with bits already at 1 and partly with bits already at 0. This separates a true OR, AND-NOT or XOR from a plain replace, and catches a swapped operation order in the decode. Write data carries 1s above the pin count and in lanes whose select is off, so lane masking and truncation can be observed. Each register is read back through an address other than the one written, which exposes alias decode errors. The input is read right after a pin change and again later, which separates a two-flop synchronizer from a one-flop one.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    // Encoding follows the low two bits of the word index (alias order).
    typedef enum logic [1:0] {
        OP_WRITE  = 2'd0,
        OP_SET    = 2'd1,
        OP_CLEAR  = 2'd2,
        OP_TOGGLE = 2'd3
    } bit_op_e;

    typedef enum logic [1:0] {
        TGT_NONE   = 2'd0,
        TGT_ENABLE = 2'd1,
        TGT_LEVEL  = 2'd2,
        TGT_PINS   = 2'd3
    } reg_tgt_e;

    typedef struct packed {
        reg_tgt_e tgt;
        bit_op_e  op;
    } reg_sel_t;

endpackage

// File: rtl/gpio_reg_decode.sv
module gpio_reg_decode
    import gpio_port_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_t          sel_o
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] word_idx;
    logic             unused_byte_bits;

    assign word_idx         = addr_i[ADDR_W-1:2];
    assign unused_byte_bits = ^addr_i[1:0];

    always_comb begin
        sel_o.op = bit_op_e'(word_idx[1:0]);
        if (word_idx < IDX_W'(4)) begin
            sel_o.tgt = TGT_ENABLE;
        end else if (word_idx < IDX_W'(8)) begin
            sel_o.tgt = TGT_LEVEL;
        end else if (word_idx == IDX_W'(8)) begin
            sel_o.tgt = TGT_PINS;
            sel_o.op  = OP_WRITE;
        end else begin
            sel_o.tgt = TGT_NONE;
            sel_o.op  = OP_WRITE;
        end
    end

endmodule

// File: rtl/gpio_mask_update.sv
module gpio_mask_update
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] cur_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic [WIDTH-1:0] lane_i,
    input  bit_op_e          op_i,
    input  logic             en_i,
    output logic [WIDTH-1:0] nxt_o
);
    logic [WIDTH-1:0] eff_mask;

    assign eff_mask = data_i & lane_i;

    always_comb begin
        nxt_o = cur_i;
        if (en_i) begin
            unique case (op_i)
                OP_WRITE:  nxt_o = (cur_i & ~lane_i) | eff_mask;
                OP_SET:    nxt_o = cur_i | eff_mask;
                OP_CLEAR:  nxt_o = cur_i & ~eff_mask;
                OP_TOGGLE: nxt_o = cur_i ^ eff_mask;
                default:   nxt_o = cur_i;
            endcase
        end
    end

endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int WIDTH = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] pin_o
);
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d        = sync_q;
        sync_d.meta   = pin_i;
        sync_d.stable = sync_q.meta;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign pin_o = sync_q.stable;

endmodule

// File: rtl/gpio_alias_port.sv
module gpio_alias_port
    import gpio_port_pkg::*;
#(
    parameter int NUM_PINS = 16,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 8
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                bus_cyc_i,
    input  logic                bus_stb_i,
    input  logic                bus_we_i,
    input  logic [ADDR_W-1:0]   bus_adr_i,
    input  logic [DATA_W-1:0]   bus_dat_i,
    input  logic [DATA_W/8-1:0] bus_sel_i,
    output logic [DATA_W-1:0]   bus_dat_o,
    output logic                bus_ack_o,
    input  logic [NUM_PINS-1:0] pin_in_i,
    output logic [NUM_PINS-1:0] pin_out_o,
    output logic [NUM_PINS-1:0] pin_oe_o
);
    localparam int SEL_W = DATA_W / 8;

    typedef struct packed {
        logic [NUM_PINS-1:0] oe;
        logic [NUM_PINS-1:0] lvl;
        logic                ack;
        logic [DATA_W-1:0]   rdata;
    } port_state_t;

    port_state_t state_d, state_q;

    reg_sel_t            dec;
    logic                req;
    logic [DATA_W-1:0]   lane_full;
    logic [NUM_PINS-1:0] lane_pins;
    logic [NUM_PINS-1:0] data_pins;
    logic [NUM_PINS-1:0] oe_nxt;
    logic [NUM_PINS-1:0] lvl_nxt;
    logic [NUM_PINS-1:0] pins_sync;
    logic                en_oe;
    logic                en_lvl;
    logic [DATA_W-1:0]   rd_mux;
    logic                unused_upper;

    // Byte lane expansion
    for (genvar b = 0; b < SEL_W; b++) begin : g_lane
        assign lane_full[b*8 +: 8] = {8{bus_sel_i[b]}};
    end

    assign lane_pins = lane_full[NUM_PINS-1:0];
    assign data_pins = bus_dat_i[NUM_PINS-1:0];

    if (NUM_PINS < DATA_W) begin : g_upper
        assign unused_upper = ^{lane_full[DATA_W-1:NUM_PINS], bus_dat_i[DATA_W-1:NUM_PINS]};
    end else begin : g_no_upper
        assign unused_upper = 1'b0;
    end

    gpio_reg_decode #(
        .ADDR_W (ADDR_W)
    ) i_decode (
        .addr_i (bus_adr_i),
        .sel_o  (dec)
    );

    assign req    = bus_cyc_i & bus_stb_i & ~state_q.ack;
    assign en_oe  = req & bus_we_i & (dec.tgt == TGT_ENABLE);
    assign en_lvl = req & bus_we_i & (dec.tgt == TGT_LEVEL);

    gpio_mask_update #(
        .WIDTH (NUM_PINS)
    ) i_upd_oe (
        .cur_i  (state_q.oe),
        .data_i (data_pins),
        .lane_i (lane_pins),
        .op_i   (dec.op),
        .en_i   (en_oe),
        .nxt_o  (oe_nxt)
    );

    gpio_mask_update #(
        .WIDTH (NUM_PINS)
    ) i_upd_lvl (
        .cur_i  (state_q.lvl),
        .data_i (data_pins),
        .lane_i (lane_pins),
        .op_i   (dec.op),
        .en_i   (en_lvl),
        .nxt_o  (lvl_nxt)
    );

    gpio_pin_sync #(
        .WIDTH (NUM_PINS)
    ) i_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .pin_i (pin_in_i),
        .pin_o (pins_sync)
    );

    // Readback multiplexer
    always_comb begin
        rd_mux = '0;
        unique case (dec.tgt)
            TGT_ENABLE: rd_mux[NUM_PINS-1:0] = state_q.oe;
            TGT_LEVEL:  rd_mux[NUM_PINS-1:0] = state_q.lvl;
            TGT_PINS:   rd_mux[NUM_PINS-1:0] = pins_sync;
            default:    rd_mux = '0;
        endcase
    end

    always_comb begin
        state_d     = state_q;
        state_d.oe  = oe_nxt;
        state_d.lvl = lvl_nxt;
        state_d.ack = req;
        if (req) begin
            state_d.rdata = rd_mux;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign bus_ack_o = state_q.ack;
    assign bus_dat_o = state_q.rdata;
    assign pin_oe_o  = state_q.oe;
    assign pin_out_o = state_q.lvl & state_q.oe;

    // Assertions
    AST_ACK_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (rst_i)
        (bus_cyc_i && bus_stb_i && !bus_ack_o) |=> bus_ack_o); // R2
    AST_ACK_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i)
        bus_ack_o |=> !bus_ack_o); // R2
    AST_SET_KEEPS_ONES: assert property (@(posedge clk_i) disable iff (rst_i)
        (req && bus_we_i && dec.tgt == TGT_LEVEL && dec.op == OP_SET)
        |=> ((state_q.lvl & $past(state_q.lvl)) == $past(state_q.lvl))); // R5
    AST_CLEAR_KEEPS_ZEROS: assert property (@(posedge clk_i) disable iff (rst_i)
        (req && bus_we_i && dec.tgt == TGT_ENABLE && dec.op == OP_CLEAR)
        |=> ((state_q.oe | $past(state_q.oe)) == $past(state_q.oe))); // R6
    AST_NO_LANE_NO_CHANGE: assert property (@(posedge clk_i) disable iff (rst_i)
        (req && bus_we_i && bus_sel_i == '0)
        |=> ($stable(pin_oe_o) && $stable(state_q.lvl))); // R12
    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        (req && !bus_we_i && dec.tgt == TGT_NONE) |=> (bus_dat_o == '0)); // R11
    AST_UNMAPPED_WRITE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (req && bus_we_i && (dec.tgt == TGT_NONE || dec.tgt == TGT_PINS))
        |=> ($stable(pin_oe_o) && $stable(state_q.lvl))); // R11

endmodule

// File: tb/test_gpio_alias_port.sv
`timescale 1ns/1ps
module test_gpio_alias_port;
    localparam int NP = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic        cyc, stb, we;
    logic [7:0]  adr;
    logic [31:0] dat_w;
    logic [3:0]  sel;
    logic [31:0] dat_r;
    logic        ack;
    logic [NP-1:0] pin_in, pin_out, pin_oe;

    always #2.5 clk = ~clk;

    gpio_alias_port i_gpio_alias_port (
        .clk_i(clk), .rst_i(rst), .bus_cyc_i(cyc), .bus_stb_i(stb), .bus_we_i(we),
        .bus_adr_i(adr), .bus_dat_i(dat_w), .bus_sel_i(sel), .bus_dat_o(dat_r),
        .bus_ack_o(ack), .pin_in_i(pin_in), .pin_out_o(pin_out), .pin_oe_o(pin_oe)
    );

    typedef struct {
        bit          is_rd;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t       sb_q[$];
    int          n_chk  = 0;
    int          n_fail = 0;
    logic [NP-1:0] oe_m  = '0;
    logic [NP-1:0] lvl_m = '0;
    logic [NP-1:0] sync_m = '0;

    function automatic logic [NP-1:0] upd(logic [NP-1:0] cur, logic [1:0] op,
                                          logic [31:0] d, logic [3:0] s);
        logic [31:0] lane;
        logic [NP-1:0] m, l;
        for (int b = 0; b < 4; b++) lane[b*8 +: 8] = {8{s[b]}};
        l = lane[NP-1:0];
        m = d[NP-1:0] & l;
        case (op)
            2'd0: return (cur & ~l) | m;
            2'd1: return cur | m;
            2'd2: return cur & ~m;
            default: return cur ^ m;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected items on each acknowledge
    always @(negedge clk) begin
        if (!rst && ack === 1'b1) begin
            if (sb_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R2: acknowledge without request, actual 1 expected 0");
            end else begin
                item_t it;
                it = sb_q.pop_front();
                if (it.is_rd) check(it.tag, dat_r, it.exp);
            end
        end
    end

    task automatic access(input bit w, input logic [7:0] a, input logic [31:0] d,
                          input logic [3:0] s, input logic [31:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        cyc = 1'b1; stb = 1'b1; we = w; adr = a; dat_w = d; sel = s;
        it.is_rd = !w; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        @(posedge clk);
        @(negedge clk);
        if (ack !== 1'b1) check({tag, " R2 ack"}, {31'd0, ack}, 32'd1);
        cyc = 1'b0; stb = 1'b0; we = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s,
                      input string tag);
        logic [5:0] idx;
        idx = a[7:2];
        if (idx < 4)      oe_m  = upd(oe_m, idx[1:0], d, s);
        else if (idx < 8) lvl_m = upd(lvl_m, idx[1:0], d, s);
        access(1'b1, a, d, s, 32'd0, tag);
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        logic [5:0] idx;
        logic [31:0] e;
        idx = a[7:2];
        e = '0;
        if (idx < 4)       e[NP-1:0] = oe_m;
        else if (idx < 8)  e[NP-1:0] = lvl_m;
        else if (idx == 8) e[NP-1:0] = sync_m;
        access(1'b0, a, 32'd0, 4'd0, e, tag);
    endtask

    task automatic chk_pins(input string tag);
        check({tag, " oe"},  {16'd0, pin_oe},  {16'd0, oe_m});
        check({tag, " out"}, {16'd0, pin_out}, {16'd0, lvl_m & oe_m});
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        rst = 1'b1; cyc = 1'b0; stb = 1'b0; we = 1'b0;
        adr = '0; dat_w = '0; sel = '0; pin_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 ack in reset", {31'd0, ack}, 32'd0);
        chk_pins("R1 reset pins");
        rst = 1'b0;
        rd(8'h00, "R1 enable after reset");
        rd(8'h10, "R1 level after reset");

        // R4 replace with bits above pin count
        wr(8'h00, 32'hFFFF_5A5A, 4'hF, "R4 enable replace");
        rd(8'h04, "R8 enable via set alias");
        rd(8'h0C, "R8 enable via invert alias");
        wr(8'h10, 32'h0000_1234, 4'hF, "R4 level replace");
        rd(8'h18, "R8 level via clear alias");
        chk_pins("R9 gated outputs");

        // R5 / R6 / R7 on level register
        wr(8'h14, 32'h0000_00F0, 4'hF, "R5 level set");
        rd(8'h10, "R5 level after set");
        wr(8'h18, 32'h0000_0234, 4'hF, "R6 level clear");
        rd(8'h1C, "R6 level after clear");
        wr(8'h1C, 32'h0000_FF0F, 4'hF, "R7 level invert");
        rd(8'h14, "R7 level after invert");
        chk_pins("R9 after level ops");

        // R5 / R6 / R7 on enable register
        wr(8'h04, 32'h0000_0101, 4'hF, "R5 enable set");
        rd(8'h00, "R5 enable after set");
        wr(8'h08, 32'h0000_5003, 4'hF, "R6 enable clear");
        rd(8'h08, "R6 enable after clear");
        wr(8'h0C, 32'h0000_00FF, 4'hF, "R7 enable invert");
        rd(8'h00, "R7 enable after invert");
        chk_pins("R9 after enable ops");

        // R12 byte lanes
        wr(8'h10, 32'h0000_ABCD, 4'b0001, "R12 low lane only");
        rd(8'h10, "R12 level after lane write");
        wr(8'h1C, 32'h0000_FFFF, 4'b0010, "R12 invert upper lane");
        rd(8'h10, "R12 level after lane invert");
        wr(8'h00, 32'h0000_FFFF, 4'b0000, "R12 zero select enable");
        wr(8'h14, 32'h0000_FFFF, 4'b0000, "R12 zero select level");
        rd(8'h00, "R12 enable unchanged");
        rd(8'h10, "R12 level unchanged");
        chk_pins("R12 pins unchanged");

        // R11 unmapped
        wr(8'h24, 32'hFFFF_FFFF, 4'hF, "R11 unmapped write");
        wr(8'h20, 32'hFFFF_FFFF, 4'hF, "R11 write to input reg");
        rd(8'h24, "R11 unmapped read");
        rd(8'hFC, "R11 top unmapped read");
        rd(8'h00, "R11 enable untouched");
        rd(8'h10, "R11 level untouched");

        // R3 low address bits ignored
        rd(8'h13, "R3 byte offset ignored");
        rd(8'h06, "R3 byte offset on enable");

        // R10 synchronizer
        @(negedge clk);
        pin_in = 16'hC5A3;
        rd(8'h20, "R10 input before sync");
        sync_m = 16'hC5A3;
        rd(8'h20, "R10 input after sync");
        @(negedge clk);
        pin_in = 16'h1F9B;
        rd(8'h20, "R10 second change early");
        sync_m = 16'h1F9B;
        rd(8'h23, "R10 second change late");

        repeat (3) @(negedge clk);
        check("R2 every request acknowledged", sb_q.size(), 32'd0);
        finish_run();
    end

endmodule